// File: doc/BRIEF.md
# USB Port Status and Control Register

This block holds the software-visible status and control word of one port in a USB host/OTG controller. It also contains the behaviour that belongs to that word. A bus write loads the control fields on the next clock edge. A read returns a word assembled from the stored fields, the live PHY suspend status and the current power and mode conditions. The three wake-event enables are masked whenever the port is unpowered. The connect and disconnect enables are also masked in device mode.

The block drives a low-power suspend request to the PHY. In device mode that request drops by itself when resume signalling is detected or a resume is forced. While the PHY reports suspend, an enabled over-current, disconnect or connect event raises a wake request, which is held until the suspend request clears. The 4-bit test field is decoded into one-hot strobes for the five defined USB test modes. Connect and disconnect events are passed on only while the port is powered.

Top module: `uport_ctl`

## Requirements
- R1: A write with `wr_en` high loads bit 23 (suspend request), bits 22/21/20 (wake enables for over-current/disconnect/connect), bits 19:16 (test code) and bit 12 (port power) on that clock edge. `phy_susp_req` and `rd_data` show the new values from then on. All of these reset to 0.
- R2: `rd_data` bit 13 (port owner), bits 15:14 and every bit not named in R1 always read 0, whatever was written.
- R3: While port power is 0, `rd_data` bits 22:20 read 0. The stored enables reappear once power is set again.
- R4: While `host_mode` is 0 (device mode), `rd_data` bits 21:20 read 0.
- R5: `rd_data` bit 23 always equals the `phy_susp_stat` input, not the stored request.
- R6: In device mode, `resume_det` or `force_resume` high at a clock edge clears `phy_susp_req` at that edge. This clear wins over a same-cycle write of 1 to bit 23.
- R7: In host mode, `resume_det` and `force_resume` do not change `phy_susp_req`.
- R8: Test codes 1 to 5 (J state, K state, SEQ_NAK, test packet, force enable) drive `tst_sel[0]` to `tst_sel[4]` respectively, one bit at a time. Code 0 drives no strobe.
- R9: Test codes 6 to 15 are stored and read back unchanged in bits 19:16, but drive no strobe.
- R10: `wake_req` rises on the edge after a cycle in which `phy_susp_stat` is 1 and an event whose enable reads 1 (per R3/R4) is present. It stays high until the edge at which `phy_susp_req` becomes 0, and falls together with it. An event whose enable reads 0 has no effect.
- R11: `conn_rpt` and `disc_rpt` follow `conn_evt` and `disc_evt` only while port power is 1, and are 0 otherwise.
- R12: With `HOST_CAPABLE` = 0, port power stays 0 and bit 12 reads 0 even after a write of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| host_mode | input | 1 | 1 = host, 0 = device |
| resume_det | input | 1 | Resume signalling detected |
| force_resume | input | 1 | Port resume being forced |
| phy_susp_stat | input | 1 | PHY reports it is in low-power suspend |
| conn_evt | input | 1 | Device connect event |
| disc_evt | input | 1 | Device disconnect event |
| ovc_evt | input | 1 | Over-current event |
| phy_susp_req | output | 1 | Low-power suspend request to the PHY |
| wake_req | output | 1 | Wake request |
| tst_sel | output | 5 | One-hot test-mode strobes (J, K, SEQ_NAK, packet, force enable) |
| conn_rpt | output | 1 | Connect event, gated by port power |
| disc_rpt | output | 1 | Disconnect event, gated by port power |

## Verification
Two pairs of functions can act in the same cycle. One pair is a software write that sets the suspend bit and the automatic clear on resume. The other is a wake event and the clear of the suspend request that ends the wake. Directed steps drive the write together with `resume_det` or `force_resume` in device mode, then again in host mode. Further steps raise events while the suspend request is being cleared. A behavioural model, updated every clock, judges the result on each cycle: it says which of the two wins and when `wake_req` falls. A long pseudo-random phase then lets the pairs meet in other combinations.

// File: rtl/uport_pkg.sv
package uport_pkg;

    localparam int DATA_W     = 32;
    localparam int CODE_W     = 4;
    localparam int N_TMODE    = 5;

    localparam int BIT_SUSP   = 23;
    localparam int BIT_EN_OC  = 22;
    localparam int BIT_EN_DC  = 21;
    localparam int BIT_EN_CN  = 20;
    localparam int BIT_CODE_L = 16;
    localparam int BIT_OWNER  = 13;
    localparam int BIT_PWR    = 12;

    typedef enum logic [CODE_W-1:0] {
        TM_OFF    = 4'd0,
        TM_J      = 4'd1,
        TM_K      = 4'd2,
        TM_SEQNAK = 4'd3,
        TM_PACKET = 4'd4,
        TM_FORCE  = 4'd5
    } tmode_e;

    typedef struct packed {
        logic              susp;
        logic              en_oc;
        logic              en_dc;
        logic              en_cn;
        logic [CODE_W-1:0] code;
        logic              pwr;
    } port_reg_t;

endpackage

// File: rtl/uport_regs.sv
module uport_regs
    import uport_pkg::*;
#(
    parameter bit HOST_CAPABLE = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  port_reg_t wr_fields,
    input  logic      auto_clr,
    output port_reg_t st_q,
    output logic      susp_nxt
);

    port_reg_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en_oc = wr_fields.en_oc;
            st_d.en_dc = wr_fields.en_dc;
            st_d.en_cn = wr_fields.en_cn;
            st_d.code  = wr_fields.code;
            st_d.pwr   = HOST_CAPABLE ? wr_fields.pwr : 1'b0;
            st_d.susp  = wr_fields.susp;
        end
        if (auto_clr) begin
            st_d.susp = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign susp_nxt = st_d.susp;

endmodule

// File: rtl/uport_wake.sv
module uport_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic phy_susp_stat,
    input  logic susp_nxt,
    input  logic ovc_evt,
    input  logic disc_evt,
    input  logic conn_evt,
    input  logic en_oc_eff,
    input  logic en_dc_eff,
    input  logic en_cn_eff,
    output logic wake_req
);

    logic wake_d, wake_q;
    logic hit;

    always_comb begin
        hit    = phy_susp_stat & ((ovc_evt  & en_oc_eff) |
                                  (disc_evt & en_dc_eff) |
                                  (conn_evt & en_cn_eff));
        wake_d = susp_nxt & (wake_q | hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= wake_d;
        end
    end

    assign wake_req = wake_q;

endmodule

// File: rtl/uport_tdec.sv
module uport_tdec
    import uport_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    output logic [N_TMODE-1:0] tst_sel
);

    for (genvar i = 0; i < N_TMODE; i++) begin : g_sel
        assign tst_sel[i] = (code == CODE_W'(i + 1));
    end

endmodule

// File: rtl/uport_ctl.sv
module uport_ctl
    import uport_pkg::*;
#(
    parameter bit HOST_CAPABLE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               host_mode,
    input  logic               resume_det,
    input  logic               force_resume,
    input  logic               phy_susp_stat,
    input  logic               conn_evt,
    input  logic               disc_evt,
    input  logic               ovc_evt,
    output logic               phy_susp_req,
    output logic               wake_req,
    output logic [N_TMODE-1:0] tst_sel,
    output logic               conn_rpt,
    output logic               disc_rpt
);

    port_reg_t wr_fields;
    port_reg_t st_q;
    logic      susp_nxt;
    logic      auto_clr;
    logic      en_oc_eff, en_dc_eff, en_cn_eff;
    logic      unused_wr;

    always_comb begin
        wr_fields       = '0;
        wr_fields.susp  = wr_data[BIT_SUSP];
        wr_fields.en_oc = wr_data[BIT_EN_OC];
        wr_fields.en_dc = wr_data[BIT_EN_DC];
        wr_fields.en_cn = wr_data[BIT_EN_CN];
        wr_fields.code  = wr_data[BIT_CODE_L +: CODE_W];
        wr_fields.pwr   = wr_data[BIT_PWR];
    end

    assign unused_wr = ^{wr_data[DATA_W-1:BIT_SUSP+1],
                         wr_data[BIT_CODE_L-1:BIT_PWR+1],
                         wr_data[BIT_PWR-1:0]};

    assign auto_clr = ~host_mode & (resume_det | force_resume);

    uport_regs #(.HOST_CAPABLE(HOST_CAPABLE)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_fields (wr_fields),
        .auto_clr  (auto_clr),
        .st_q      (st_q),
        .susp_nxt  (susp_nxt)
    );

    always_comb begin
        en_oc_eff = st_q.en_oc & st_q.pwr;
        en_dc_eff = st_q.en_dc & st_q.pwr & host_mode;
        en_cn_eff = st_q.en_cn & st_q.pwr & host_mode;
    end

    uport_wake i_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .phy_susp_stat (phy_susp_stat),
        .susp_nxt      (susp_nxt),
        .ovc_evt       (ovc_evt),
        .disc_evt      (disc_evt),
        .conn_evt      (conn_evt),
        .en_oc_eff     (en_oc_eff),
        .en_dc_eff     (en_dc_eff),
        .en_cn_eff     (en_cn_eff),
        .wake_req      (wake_req)
    );

    uport_tdec i_tdec (
        .code    (st_q.code),
        .tst_sel (tst_sel)
    );

    always_comb begin
        rd_data                          = '0;
        rd_data[BIT_SUSP]                = phy_susp_stat;
        rd_data[BIT_EN_OC]               = en_oc_eff;
        rd_data[BIT_EN_DC]               = en_dc_eff;
        rd_data[BIT_EN_CN]               = en_cn_eff;
        rd_data[BIT_CODE_L +: CODE_W]    = st_q.code;
        rd_data[BIT_OWNER]               = 1'b0;
        rd_data[BIT_PWR]                 = st_q.pwr;
    end

    assign phy_susp_req = st_q.susp;
    assign conn_rpt     = conn_evt & st_q.pwr;
    assign disc_rpt     = disc_evt & st_q.pwr;

endmodule

// File: rtl/uport_chk.sv
module uport_chk
    import uport_pkg::*;
#(
    parameter bit HOST_CAPABLE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic [DATA_W-1:0]  rd_data,
    input logic               host_mode,
    input logic               resume_det,
    input logic               force_resume,
    input logic               phy_susp_stat,
    input logic               conn_evt,
    input logic               disc_evt,
    input logic               phy_susp_req,
    input logic               wake_req,
    input logic [N_TMODE-1:0] tst_sel,
    input logic               conn_rpt,
    input logic               disc_rpt
);

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(!host_mode && (resume_det || force_resume)))
        |=> phy_susp_req == $past(wr_data[BIT_SUSP])); // R1

    AST_OWNER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_OWNER] == 1'b0 && rd_data[15:14] == 2'b00); // R2

    AST_UNPOWERED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[BIT_PWR] |-> rd_data[BIT_EN_OC:BIT_EN_CN] == 3'b000); // R3

    AST_DEVICE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |-> rd_data[BIT_EN_DC:BIT_EN_CN] == 2'b00); // R4

    AST_SUSP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_SUSP] == phy_susp_stat); // R5

    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_mode && (resume_det || force_resume)) |=> !phy_susp_req); // R6

    AST_HOST_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && !wr_en && phy_susp_req) |=> phy_susp_req); // R7

    AST_TEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tst_sel)); // R8

    AST_WAKE_NEEDS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> phy_susp_req); // R10

    AST_EVENT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[BIT_PWR] |-> (!conn_rpt && !disc_rpt)); // R11

    AST_EVENT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_PWR] |-> (conn_rpt == conn_evt && disc_rpt == disc_evt)); // R11

    if (!HOST_CAPABLE) begin : g_devonly
        AST_NO_POWER: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[BIT_PWR] == 1'b0); // R12
    end

endmodule

bind uport_ctl uport_chk #(.HOST_CAPABLE(HOST_CAPABLE)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .host_mode     (host_mode),
    .resume_det    (resume_det),
    .force_resume  (force_resume),
    .phy_susp_stat (phy_susp_stat),
    .conn_evt      (conn_evt),
    .disc_evt      (disc_evt),
    .phy_susp_req  (phy_susp_req),
    .wake_req      (wake_req),
    .tst_sel       (tst_sel),
    .conn_rpt      (conn_rpt),
    .disc_rpt      (disc_rpt)
);

// File: tb/test_uport_ctl.sv
module test_uport_ctl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        host_mode = 1'b1;
    logic        resume_det = 1'b0;
    logic        force_resume = 1'b0;
    logic        phy_susp_stat = 1'b0;
    logic        conn_evt = 1'b0;
    logic        disc_evt = 1'b0;
    logic        ovc_evt = 1'b0;

    logic [31:0] rd_data, rd_dev;
    logic        phy_susp_req, wake_req, conn_rpt, disc_rpt;
    logic [4:0]  tst_sel, tst_dev;
    logic        susp_dev, wake_dev, conn_dev, disc_dev;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit       m_susp, m_oc, m_dc, m_cn, m_pp, m_wake;
    bit [3:0] m_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    uport_ctl i_uport_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .host_mode(host_mode), .resume_det(resume_det),
        .force_resume(force_resume), .phy_susp_stat(phy_susp_stat),
        .conn_evt(conn_evt), .disc_evt(disc_evt), .ovc_evt(ovc_evt),
        .phy_susp_req(phy_susp_req), .wake_req(wake_req), .tst_sel(tst_sel),
        .conn_rpt(conn_rpt), .disc_rpt(disc_rpt)
    );

    uport_ctl #(.HOST_CAPABLE(1'b0)) i_uport_ctl_dev (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_dev), .host_mode(host_mode), .resume_det(resume_det),
        .force_resume(force_resume), .phy_susp_stat(phy_susp_stat),
        .conn_evt(conn_evt), .disc_evt(disc_evt), .ovc_evt(ovc_evt),
        .phy_susp_req(susp_dev), .wake_req(wake_dev), .tst_sel(tst_dev),
        .conn_rpt(conn_dev), .disc_rpt(disc_dev)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        r[23]    = phy_susp_stat;
        r[22]    = m_oc & m_pp;
        r[21]    = m_dc & m_pp & host_mode;
        r[20]    = m_cn & m_pp & host_mode;
        r[19:16] = m_code;
        r[12]    = m_pp;
        return r;
    endfunction

    function automatic logic [4:0] exp_sel();
        if (m_code >= 4'd1 && m_code <= 4'd5) return 5'(1) << (m_code - 4'd1);
        return 5'd0;
    endfunction

    task automatic compare_all();
        logic [31:0] e = exp_rd();
        chk("R5 suspend read",        32'(rd_data[23]),    32'(e[23]));
        chk("R3 R4 wake enables",     32'(rd_data[22:20]), 32'(e[22:20]));
        chk("R1 R9 test code",        32'(rd_data[19:16]), 32'(e[19:16]));
        chk("R1 port power",          32'(rd_data[12]),    32'(e[12]));
        chk("R2 zero bits",           {rd_data[31:24], rd_data[15:13], rd_data[11:0]}, 32'd0);
        chk("R6 R7 suspend request",  32'(phy_susp_req),   32'(m_susp));
        chk("R10 wake request",       32'(wake_req),       32'(m_wake));
        chk("R8 test strobes",        32'(tst_sel),        32'(exp_sel()));
        chk("R11 connect report",     32'(conn_rpt),       32'(conn_evt & m_pp));
        chk("R11 disconnect report",  32'(disc_rpt),       32'(disc_evt & m_pp));
        chk("R12 device-only power",  32'(rd_dev[12]),     32'd0);
        chk("R12 device-only report", 32'({conn_dev, disc_dev}), 32'd0);
    endtask

    task automatic model_edge();
        bit clr, nsusp, hit;
        clr   = !host_mode && (resume_det || force_resume);
        hit   = phy_susp_stat && ((ovc_evt && m_oc && m_pp) ||
                                  (disc_evt && m_dc && m_pp && host_mode) ||
                                  (conn_evt && m_cn && m_pp && host_mode));
        nsusp = clr ? 1'b0 : (wr_en ? wr_data[23] : m_susp);
        m_wake = nsusp && (m_wake || hit);
        m_susp = nsusp;
        if (wr_en) begin
            m_oc   = wr_data[22];
            m_dc   = wr_data[21];
            m_cn   = wr_data[20];
            m_code = wr_data[19:16];
            m_pp   = wr_data[12];
        end
    endtask

    // inputs are set at a falling edge; this checks, then advances one clock
    task automatic cyc();
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; resume_det = 0; force_resume = 0;
        conn_evt = 0; disc_evt = 0; ovc_evt = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1; wr_data = d; cyc(); wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_susp = 0; m_oc = 0; m_dc = 0; m_cn = 0; m_pp = 0; m_wake = 0; m_code = 0;
        repeat (3) @(negedge clk);
        // R1 R2 reset state
        #1 compare_all();
        rst_n = 1;
        @(negedge clk);
        cyc();

        // R1 R2 R9: all ones in host mode (owner bit and reserved bits ignored)
        wr(32'hFFFF_FFFF);
        cyc();
        chk("R2 owner after write", 32'(rd_data[13]), 32'd0);

        // R8 R9: every test code
        for (int c = 0; c < 16; c++) begin
            wr(32'h0000_1000 | (32'(c) << 16));
            cyc();
        end

        // R3: enables masked while unpowered, back when powered
        wr(32'h0070_0000);
        cyc();
        chk("R3 unpowered enables", 32'(rd_data[22:20]), 32'd0);
        wr(32'h0070_1000);
        cyc();
        chk("R3 powered enables", 32'(rd_data[22:20]), 32'd7);

        // R4: device mode masks disconnect/connect enables
        host_mode = 0; cyc();
        chk("R4 device enables", 32'(rd_data[22:20]), 32'd4);
        host_mode = 1;

        // R5: live status
        phy_susp_stat = 1; cyc(); phy_susp_stat = 0; cyc();

        // R6: device-mode clear wins over same-cycle write of 1
        wr(32'h00F0_1000);
        host_mode = 0; resume_det = 1; wr(32'h00F0_1000); idle();
        chk("R6 clear beats write", 32'(phy_susp_req), 32'd0);
        wr(32'h00F0_1000);
        force_resume = 1; cyc(); idle();
        chk("R6 forced resume clears", 32'(phy_susp_req), 32'd0);

        // R7: host mode ignores resume inputs
        host_mode = 1; wr(32'h00F0_1000);
        resume_det = 1; force_resume = 1; cyc(); cyc(); idle();
        chk("R7 host keeps suspend", 32'(phy_susp_req), 32'd1);

        // R10: wake with enabled and disabled events
        phy_susp_stat = 1;
        wr(32'h0080_1000);           // suspended, all enables off
        conn_evt = 1; disc_evt = 1; ovc_evt = 1; cyc(); idle(); cyc();
        chk("R10 disabled events ignored", 32'(wake_req), 32'd0);
        wr(32'h00C0_1000);           // over-current enabled
        ovc_evt = 1; cyc(); idle(); cyc();
        chk("R10 wake held", 32'(wake_req), 32'd1);
        wr(32'h0040_1000);           // software clears suspend
        chk("R10 wake drops with suspend", 32'(wake_req), 32'd0);
        wr(32'h00A0_1000);           // disconnect wake, then device resume
        disc_evt = 1; cyc(); idle();
        host_mode = 0; ovc_evt = 1; resume_det = 1; cyc(); idle();
        chk("R10 R6 resume ends wake", 32'(wake_req), 32'd0);
        host_mode = 1;

        // R11: event gating
        wr(32'h0000_0000); conn_evt = 1; disc_evt = 1; cyc(); idle();
        wr(32'h0000_1000); conn_evt = 1; disc_evt = 1; cyc(); idle();

        // pseudo-random phase, model compared every clock
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r = $urandom;
            wr_en         = (r[3:0] == 4'd0);
            wr_data       = $urandom;
            host_mode     = r[4] | r[5];
            resume_det    = (r[9:6] == 4'd0);
            force_resume  = (r[13:10] == 4'd0);
            phy_susp_stat = r[14] | r[15];
            conn_evt      = r[16] & r[17];
            disc_evt      = r[18] & r[19];
            ovc_evt       = r[20] & r[21];
            cyc();
        end
        idle();
        cyc();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule